// File: doc/BRIEF.md
# Five-Level Bridge Gate Sequencer

This block drives the eight gate inputs of two full bridges whose AC outputs are wired in series. The sum of the two bridge outputs is a single-phase staircase with five levels: zero, plus or minus one cell voltage, and plus or minus two cell voltages. A free-running step timer walks through an eight-step staircase. With the default step length of 125000 clocks at 50 MHz, each step lasts 2.5 ms and the whole staircase repeats every 20 ms, which gives a 50 Hz output.

Every new step begins with a blanking window of a parameter number of clocks. During that window all gates are held off, and the new switch pattern is applied only after the window ends. This keeps the two devices of one leg from conducting together while they hand over. Deasserting the enable input, or asserting the shutdown input (for example from a low-supply monitor), turns all gates off on the next clock edge and rewinds the staircase. Once the block is active again, it restarts from the first step. A signed level code shows which level the current step commands.

Top module: `stair_gate_seq`

## Requirements
- R1: While `rst` is high at a clock edge, both `gatesOut` and `levelOut` are 0 after that edge.
- R2: `gatesOut` bits 0..3 drive bridge A switches a1, a2, a3, a4, and bits 4..7 drive bridge B switches b1, b2, b3, b4. The words are fixed per level: level +1 = 8'h09 (a1, a4), level +2 = 8'h99 (a1, a4, b1, b4), level -1 = 8'h06 (a2, a3), level -2 = 8'h66 (a2, a3, b2, b3), level 0 = 8'h00.
- R3: `levelOut` is a 3-bit two's-complement code in the range -2..+2, and it equals the level of the current step.
- R4: Step k of each period (k = 0..7) commands the level 0, +1, +2, +1, 0, -1, -2, -1. After step 7 the sequence returns to step 0.
- R5: Each step lasts exactly STEP_CYCLES clock edges, so one period is 8*STEP_CYCLES edges. `levelOut` takes the new step's level after the first edge of that step.
- R6: During the first DEAD_CYCLES edges of every step, `gatesOut` is 8'h00. For the rest of the step it holds the word of that step's level.
- R7: The pairs (bit 0, bit 2), (bit 1, bit 3), (bit 4, bit 6) and (bit 5, bit 7) are never high together.
- R8: After any edge at which `shutdown` is high, both outputs are 0 and the staircase is rewound to step 0.
- R9: After any edge at which `enable` is low, both outputs are 0 and the staircase is rewound to step 0.
- R10: The first edge with `enable` high and `shutdown` low after an idle spell is the first edge of step 0. Timing then proceeds as in R5 and R6.
- R11: `gatesOut` never moves from one nonzero word to a different nonzero word without passing through 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request; low holds the block idle |
| shutdown | input | 1 | Fault stop, active high; overrides enable |
| gatesOut | output | 8 | Gate commands, bridge A in bits 3:0, bridge B in bits 7:4 |
| levelOut | output | 3 | Signed level code of the current step |

## Verification
Edges are counted from the first active edge, which is numbered 0. After edge n, the level code must already show step (n / STEP_CYCLES) mod 8, with one register between the step counter and the port. The gate word is due on the same edge, but it stays zero while n mod STEP_CYCLES is below DEAD_CYCLES. Shutdown and enable-low are due one edge after they are sampled, so the bench changes inputs at a falling edge and compares every output at the following falling edge against a model indexed by the edge count. Each resume is checked from a fresh count of zero.

// File: rtl/stair_pkg.sv
package stair_pkg;

  typedef logic signed [2:0] level_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   blank;  // force every gate off this cycle
    level_t level;  // level commanded by the current step
  } strobe_t;

  // Level of each of the eight steps in one output period
  function automatic level_t stepLevel(input logic [2:0] idx);
    level_t lvl;
    case (idx)
      3'd1, 3'd3: lvl = 3'sd1;
      3'd2:       lvl = 3'sd2;
      3'd5, 3'd7: lvl = -3'sd1;
      3'd6:       lvl = -3'sd2;
      default:    lvl = 3'sd0;
    endcase
    return lvl;
  endfunction

  // Switch word per level: bridge A in bits 3:0, bridge B in bits 7:4
  function automatic logic [7:0] gateWord(input level_t lvl);
    logic [7:0] w;
    case (lvl)
      3'b001:  w = 8'h09;
      3'b010:  w = 8'h99;
      3'b111:  w = 8'h06;
      3'b110:  w = 8'h66;
      default: w = 8'h00;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/stair_ctrl.sv
module stair_ctrl
  import stair_pkg::*;
#(
  parameter int STEP_CYCLES = 125000,
  parameter int DEAD_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  logic    shutdown,
  output strobe_t strobe
);

  localparam int CNT_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(STEP_CYCLES - 1);

  logic             active;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       stepIdx;
  logic             inDead;

  assign active = enable && !shutdown;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      tickCnt <= '0;
      stepIdx <= 3'd0;
    end else if (tickCnt == LAST_TICK) begin
      tickCnt <= '0;
      stepIdx <= stepIdx + 3'd1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  generate
    if (DEAD_CYCLES == 0) begin : g_noDead
      assign inDead = 1'b0;
    end else begin : g_dead
      localparam logic [CNT_W-1:0] DEAD_END = CNT_W'(DEAD_CYCLES);
      assign inDead = (tickCnt < DEAD_END);
    end
  endgenerate

  always_comb begin
    strobe.blank = !active || inDead;
    strobe.level = active ? stepLevel(stepIdx) : 3'sd0;
  end

  // R5: the in-step counter never passes the last tick of a step
  assert_tick_bound_R5: assert property (@(posedge clk) disable iff (rst)
    tickCnt <= LAST_TICK);

  // R8 / R9: any idle cycle rewinds the staircase to the first step
  assert_idle_rewind_R8: assert property (@(posedge clk) disable iff (rst)
    !active |=> (stepIdx == 3'd0 && tickCnt == '0));

endmodule

// File: rtl/stair_dp.sv
module stair_dp
  import stair_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strobe,
  output logic [7:0] gatesQ,
  output level_t     levelQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      gatesQ <= 8'h00;
      levelQ <= 3'sd0;
    end else begin
      levelQ <= strobe.level;
      gatesQ <= strobe.blank ? 8'h00 : gateWord(strobe.level);
    end
  end

  // R7: no leg of either bridge ever has both devices on
  assert_no_shoot_R7: assert property (@(posedge clk) disable iff (rst)
    !(gatesQ[0] && gatesQ[2]) && !(gatesQ[1] && gatesQ[3]) &&
    !(gatesQ[4] && gatesQ[6]) && !(gatesQ[5] && gatesQ[7]));

  // R11: two different conducting words are always separated by all-off
  assert_blank_between_R11: assert property (@(posedge clk) disable iff (rst)
    (gatesQ != 8'h00 && $past(gatesQ) != 8'h00) |-> gatesQ == $past(gatesQ));

  // R3: the level code stays within the five legal values
  assert_level_range_R3: assert property (@(posedge clk) disable iff (rst)
    (levelQ >= -3'sd2) && (levelQ <= 3'sd2));

  // R2: a positive level never closes a negative-polarity device
  assert_polarity_R2: assert property (@(posedge clk) disable iff (rst)
    (levelQ > 3'sd0) |-> ((gatesQ & 8'h66) == 8'h00));

endmodule

// File: rtl/stair_gate_seq.sv
module stair_gate_seq
  import stair_pkg::*;
#(
  parameter int STEP_CYCLES = 125000,
  parameter int DEAD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              shutdown,
  output logic [7:0]        gatesOut,
  output logic signed [2:0] levelOut
);

  strobe_t strobe;
  level_t  levelQ;

  stair_ctrl #(
    .STEP_CYCLES(STEP_CYCLES),
    .DEAD_CYCLES(DEAD_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .shutdown(shutdown),
    .strobe  (strobe)
  );

  stair_dp u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .gatesQ(gatesOut),
    .levelQ(levelQ)
  );

  assign levelOut = levelQ;

  // R8: a shutdown sample clears every output on the next edge
  assert_shutdown_off_R8: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (gatesOut == 8'h00 && levelOut == 3'sd0));

  // R9: a disabled sample clears every output on the next edge
  assert_disable_off_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (gatesOut == 8'h00 && levelOut == 3'sd0));

endmodule

// File: tb/stair_gate_seq_test.sv
module stair_gate_seq_test;

  localparam int STEP = 20;
  localparam int DEAD = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic              shutdown = 1'b0;
  logic [7:0]        gatesOut;
  logic signed [2:0] levelOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stair_gate_seq #(.STEP_CYCLES(STEP), .DEAD_CYCLES(DEAD)) uut (
    .clk(clk), .rst(rst), .enable(enable), .shutdown(shutdown),
    .gatesOut(gatesOut), .levelOut(levelOut)
  );

  // Expected level of step k (R4)
  function automatic int refLevel(input int k);
    case (k % 8)
      1, 3: return 1;
      2:    return 2;
      5, 7: return -1;
      6:    return -2;
      default: return 0;
    endcase
  endfunction

  // Expected gate word for a level (R2)
  function automatic int refWord(input int lvl);
    case (lvl)
      1:  return 'h09;
      2:  return 'h99;
      -1: return 'h06;
      -2: return 'h66;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Call at a falling edge with the inputs already active; edge 0 is the next rising edge
  task automatic runAndCheck(input int cycles, input string tag);
    int prevG = gatesOut;
    for (int n = 0; n < cycles; n++) begin
      int lvl;
      int word;
      @(posedge clk);
      @(negedge clk);
      lvl  = refLevel(n / STEP);
      word = ((n % STEP) < DEAD) ? 0 : refWord(lvl);
      check(int'(gatesOut) == word, {tag, " R2 R6 gates"}, gatesOut, word);
      check(int'(levelOut) == lvl, {tag, " R3 R4 R5 level"}, levelOut, lvl);
      check(!((gatesOut[0] && gatesOut[2]) || (gatesOut[1] && gatesOut[3]) ||
              (gatesOut[4] && gatesOut[6]) || (gatesOut[5] && gatesOut[7])),
            {tag, " R7 leg pair"}, gatesOut, 0);
      check(!(prevG != 0 && gatesOut != 0 && int'(gatesOut) != prevG),
            {tag, " R11 direct change"}, gatesOut, 0);
      prevG = gatesOut;
    end
  endtask

  task automatic expectIdle(input int cycles, input string tag);
    for (int n = 0; n < cycles; n++) begin
      @(posedge clk);
      @(negedge clk);
      check(gatesOut == 8'h00, {tag, " gates off"}, gatesOut, 0);
      check(levelOut == 3'sd0, {tag, " level zero"}, levelOut, 0);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rst = 1'b1; enable = 1'b1; shutdown = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: reset state, even with enable high
  task automatic testReset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(gatesOut == 8'h00, "R1 gates in reset", gatesOut, 0);
    check(levelOut == 3'sd0, "R1 level in reset", levelOut, 0);
  endtask

  // R4 R5 R6: two complete periods
  task automatic testFullRun();
    restart();
    runAndCheck(16 * STEP, "R4 run");
  endtask

  // R8 then R10: shutdown in step 2 after the dead window
  task automatic testShutdown();
    restart();
    runAndCheck(2 * STEP + 10, "R8 pre");
    shutdown = 1'b1;
    expectIdle(6, "R8");
    shutdown = 1'b0;
    runAndCheck(8 * STEP, "R10 after shutdown");
  endtask

  // R8 during a dead window, R8 with enable also low
  task automatic testShutdownInDead();
    restart();
    runAndCheck(5 * STEP + 1, "R8 pre dead");
    shutdown = 1'b1; enable = 1'b0;
    expectIdle(3, "R8 R9 both");
    enable = 1'b1;
    expectIdle(3, "R8 held");
    shutdown = 1'b0;
    runAndCheck(3 * STEP, "R10 after dead stop");
  endtask

  // R9 then R10: enable dropped in step 6
  task automatic testDisable();
    restart();
    runAndCheck(6 * STEP + 5, "R9 pre");
    enable = 1'b0;
    expectIdle(8, "R9");
    enable = 1'b1;
    runAndCheck(8 * STEP, "R10 after disable");
  endtask

  initial begin
    testReset();
    testFullRun();
    testShutdown();
    testShutdownInDead();
    testDisable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule